// File: doc/BRIEF.md
# Serial Command Frame Parser

This block sits between a UART receiver and transmitter and a command handler. It takes received bytes one at a time and recognises command frames. A frame opens with a start byte and closes with an end byte, and a fixed separator byte follows the command code and every parameter field. When a frame is complete and its command is known, the block gives the command code and its parameter fields to a handler over a request/response handshake. The handler stands for the power-control logic, the I2C engine and the analog measurement. The block then sends a response frame: an acknowledge byte, the status the handler returned, any data bytes, and the end byte.

The block only answers. It never transmits unless a frame has just arrived. It handles one command at a time: while a request is outstanding or a response is being sent, received bytes are dropped. Frames with a broken layout are discarded without a reply. Frames with an unknown command code get an unknown-command reply. A frame that runs past the length limit gets an overflow reply.

Top module: `cmd_frame_engine`

## Requirements
- R1: After reset, `tx_valid` and `req_valid` are low, and no byte is sent or requested until a frame is received.
- R2: The frame `01 44 cc 44 04` with code cc = 0x00 (disable) or 0x01 (enable) raises `req_valid` with `req_code` = cc and `req_args` = 0. `req_valid` and its fields stay stable until `rsp_valid`. The reply is `06 44 ss 44 04`, where ss is `rsp_status`, and its first byte is always 0x06.
- R3: Code 0x02 takes one field, which appears in `req_args[7:0]`. With status 0x00 the reply is `06 44 00 44 hi lo 44 04`, where hi and lo are `rsp_data[15:8]` and `rsp_data[7:0]`, high byte first.
- R4: Code 0x04 takes three fields, placed in `req_args` bytes 0, 1 and 2 in arrival order. With status 0x00 the reply is `06 44 00 44 dd 44 04`, where dd is `rsp_data[7:0]`.
- R5: Code 0x05 takes four fields, placed in `req_args` bytes 0 to 3 in arrival order. A field byte equal to 0x04 or 0x44 is taken as data. The reply carries no data: `06 44 ss 44 04`.
- R6: When the handler returns any status other than 0x00 (for example 0x06, 0x07 or 0x08), the reply is `06 44 ss 44 04` with no data bytes.
- R7: A command code of 0x03 or above 0x05 raises no request. When an end byte arrives at a field position, the reply is `06 44 01 44 04`.
- R8: When a separator is missing at an expected position, the frame is discarded with no request and no reply, and the next start byte begins a new frame.
- R9: Bytes received while no frame is open, other than 0x01, are ignored.
- R10: When a frame's 13th byte does not close it, the frame ends at once with the reply `06 44 09 44 04` and no request.
- R11: Bytes received while a request is outstanding or a reply is being sent are dropped.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold their values.
- R13: When a known command has received all its fields and the next byte is not 0x04, the frame is discarded with no request and no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present on `rx_data` this cycle |
| rx_data | input | 8 | Received byte |
| req_valid | output | 1 | A decoded command is waiting for the handler |
| req_code | output | 8 | Command code |
| req_args | output | 32 | Parameter fields, the first field in bits 7:0 |
| rsp_valid | input | 1 | One-cycle handler completion |
| rsp_status | input | 8 | Status code from the handler |
| rsp_data | input | 16 | Result data from the handler |
| tx_valid | output | 1 | A reply byte is offered on `tx_data` |
| tx_data | output | 8 | Reply byte |
| tx_ready | input | 1 | The transmitter takes the offered byte this cycle |

## Verification
Each known code is driven with its own number of fields. This separates the zero-, one-, three- and four-field paths and the zero-, one- and two-byte reply paths. The write frame includes a field equal to the end byte, and the same frame is exactly at the length limit. This shows that field counting, rather than byte matching, decides where a frame ends. Broken frames cover a missing separator, a missing end byte, noise ahead of the start byte, an unknown code and an over-long frame, each followed by a good frame or a check that nothing was sent. These tell discard, unknown-command and overflow apart. A slow handler and a stalling transmitter show that bytes are dropped while busy and that reply bytes are held.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    localparam logic [7:0] START_B = 8'h01;
    localparam logic [7:0] SEP_B   = 8'h44;
    localparam logic [7:0] END_B   = 8'h04;
    localparam logic [7:0] ACK_B   = 8'h06;

    localparam logic [7:0] ST_OK       = 8'h00;
    localparam logic [7:0] ST_UNKNOWN  = 8'h01;
    localparam logic [7:0] ST_OVERFLOW = 8'h09;

    localparam int ARG_MAX      = 4;
    localparam int AI_W         = $clog2(ARG_MAX);
    localparam int FI_W         = $clog2(ARG_MAX + 1);
    localparam int RSP_DATA_MAX = 2;
    localparam int RD_W         = RSP_DATA_MAX * 8;
    localparam int LEN_W        = $clog2(RSP_DATA_MAX + 1);

    typedef enum logic [2:0] {PS_IDLE, PS_HSEP, PS_CODE, PS_SEP, PS_BODY} pstate_t;
    typedef enum logic [1:0] {FK_CMD, FK_UNKNOWN, FK_OVERFLOW} fkind_t;
    typedef enum logic [1:0] {CS_LISTEN, CS_WAIT, CS_SEND} cstate_t;

    typedef struct packed {
        logic [7:0]       status;
        logic [RD_W-1:0]  data;
        logic [LEN_W-1:0] len;
    } rsp_req_t;

    function automatic logic cmd_known(input logic [7:0] c);
        return (c == 8'h00) || (c == 8'h01) || (c == 8'h02) || (c == 8'h04) || (c == 8'h05);
    endfunction

    function automatic logic [FI_W-1:0] cmd_fields(input logic [7:0] c);
        case (c)
            8'h02:   return FI_W'(1);
            8'h04:   return FI_W'(3);
            8'h05:   return FI_W'(4);
            default: return '0;
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] cmd_rsp_len(input logic [7:0] c);
        case (c)
            8'h02:   return LEN_W'(2);
            8'h04:   return LEN_W'(1);
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cfp_rx_parser.sv
module cfp_rx_parser
    import cfp_pkg::*;
#(
    parameter int MAX_PRE_END = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    output logic                 done,
    output fkind_t               kind,
    output logic [7:0]           code,
    output logic [ARG_MAX*8-1:0] args
);
    localparam int CNT_W = $clog2(MAX_PRE_END + 1);

    pstate_t          state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             known_q;
    logic [FI_W-1:0]  nfld_q;
    logic [FI_W-1:0]  fidx_q;
    logic [7:0]       arg_q [ARG_MAX];

    logic closes;
    assign closes = (state_q == PS_BODY) && (rx_data == END_B) &&
                    (!known_q || (fidx_q == nfld_q));

    for (genvar k = 0; k < ARG_MAX; k++) begin : g_args
        assign args[k*8 +: 8] = arg_q[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_IDLE;
            cnt_q   <= '0;
            known_q <= 1'b0;
            nfld_q  <= '0;
            fidx_q  <= '0;
            code    <= '0;
            done    <= 1'b0;
            kind    <= FK_CMD;
            for (int k = 0; k < ARG_MAX; k++) arg_q[k] <= '0;
        end else begin
            done <= 1'b0;
            if (rx_valid && enable) begin
                if (state_q == PS_IDLE) begin
                    if (rx_data == START_B) begin
                        state_q <= PS_HSEP;
                        cnt_q   <= CNT_W'(1);
                        fidx_q  <= '0;
                        for (int k = 0; k < ARG_MAX; k++) arg_q[k] <= '0;
                    end
                end else if (closes) begin
                    done    <= 1'b1;
                    kind    <= known_q ? FK_CMD : FK_UNKNOWN;
                    state_q <= PS_IDLE;
                end else if (cnt_q == CNT_W'(MAX_PRE_END)) begin
                    done    <= 1'b1;
                    kind    <= FK_OVERFLOW;
                    state_q <= PS_IDLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    case (state_q)
                        PS_HSEP: state_q <= (rx_data == SEP_B) ? PS_CODE : PS_IDLE;
                        PS_CODE: begin
                            code    <= rx_data;
                            known_q <= cmd_known(rx_data);
                            nfld_q  <= cmd_fields(rx_data);
                            state_q <= PS_SEP;
                        end
                        PS_SEP:  state_q <= (rx_data == SEP_B) ? PS_BODY : PS_IDLE;
                        PS_BODY: begin
                            if (known_q && (fidx_q == nfld_q)) begin
                                state_q <= PS_IDLE;
                            end else begin
                                if (known_q) begin
                                    arg_q[fidx_q[AI_W-1:0]] <= rx_data;
                                    fidx_q <= fidx_q + 1'b1;
                                end
                                state_q <= PS_SEP;
                            end
                        end
                        default: state_q <= PS_IDLE;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/cfp_tx_framer.sv
module cfp_tx_framer
    import cfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  rsp_req_t   req,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       done
);
    localparam int IDX_W = $clog2(6 + RSP_DATA_MAX);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       st_q;
    logic [RD_W-1:0]  sh_q;
    logic [LEN_W-1:0] len_q;

    logic is_last;
    logic in_data;

    always_comb begin
        int i;
        int l;
        i = int'(idx_q);
        l = int'(len_q);
        in_data = (i >= 4) && (i < 4 + l);
        is_last = (l == 0) ? (i == 4) : (i == 5 + l);
        if (i == 0)           tx_data = ACK_B;
        else if (i == 1)      tx_data = SEP_B;
        else if (i == 2)      tx_data = st_q;
        else if (i == 3)      tx_data = SEP_B;
        else if (in_data)     tx_data = sh_q[RD_W-1 -: 8];
        else if (is_last)     tx_data = END_B;
        else                  tx_data = SEP_B;
    end

    assign tx_valid = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            st_q   <= '0;
            sh_q   <= '0;
            len_q  <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                idx_q  <= '0;
                st_q   <= req.status;
                len_q  <= req.len;
                sh_q   <= req.data << (8 * (RSP_DATA_MAX - int'(req.len)));
            end else if (busy_q && tx_ready) begin
                if (is_last) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                    if (in_data) sh_q <= sh_q << 8;
                end
            end
        end
    end

endmodule

// File: rtl/cmd_frame_engine.sv
module cmd_frame_engine
    import cfp_pkg::*;
#(
    parameter int MAX_PRE_END = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        req_valid,
    output logic [7:0]  req_code,
    output logic [31:0] req_args,
    input  logic        rsp_valid,
    input  logic [7:0]  rsp_status,
    input  logic [15:0] rsp_data,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    input  logic        tx_ready
);
    cstate_t  cs_q;
    logic     p_done;
    fkind_t   p_kind;
    logic     f_start;
    logic     f_done;
    rsp_req_t f_req;

    cfp_rx_parser #(.MAX_PRE_END(MAX_PRE_END)) parser_i (
        .clk      (clk),
        .rst      (rst),
        .enable   ((cs_q == CS_LISTEN) && !p_done),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .done     (p_done),
        .kind     (p_kind),
        .code     (req_code),
        .args     (req_args)
    );

    always_comb begin
        f_start = 1'b0;
        f_req   = '0;
        if (cs_q == CS_LISTEN && p_done && p_kind != FK_CMD) begin
            f_start    = 1'b1;
            f_req.status = (p_kind == FK_OVERFLOW) ? ST_OVERFLOW : ST_UNKNOWN;
        end else if (cs_q == CS_WAIT && rsp_valid) begin
            f_start      = 1'b1;
            f_req.status = rsp_status;
            f_req.data   = rsp_data;
            f_req.len    = (rsp_status == ST_OK) ? cmd_rsp_len(req_code) : '0;
        end
    end

    cfp_tx_framer framer_i (
        .clk      (clk),
        .rst      (rst),
        .start    (f_start),
        .req      (f_req),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .done     (f_done)
    );

    assign req_valid = (cs_q == CS_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q <= CS_LISTEN;
        end else begin
            case (cs_q)
                CS_LISTEN: if (p_done) cs_q <= (p_kind == FK_CMD) ? CS_WAIT : CS_SEND;
                CS_WAIT:   if (rsp_valid) cs_q <= CS_SEND;
                CS_SEND:   if (f_done) cs_q <= CS_LISTEN;
                default:   cs_q <= CS_LISTEN;
            endcase
        end
    end

endmodule

// File: rtl/cfp_chk.sv
module cfp_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [7:0]  req_code,
    input logic [31:0] req_args,
    input logic        rsp_valid,
    input logic        tx_valid,
    input logic [7:0]  tx_data,
    input logic        tx_ready
);
    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R2
    ack_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_data == 8'h06));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |=> (req_valid && $stable(req_code) && $stable(req_args)));

    // R7
    known_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_code inside {8'h00, 8'h01, 8'h02, 8'h04, 8'h05}));

    // R11
    one_job_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && tx_valid));
endmodule

bind cmd_frame_engine cfp_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_code  (req_code),
    .req_args  (req_args),
    .rsp_valid (rsp_valid),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_ready  (tx_ready)
);

// File: tb/cmd_frame_engine_tb_top.sv
module cmd_frame_engine_tb_top;
    localparam time CLK_P = 10ns;

    typedef logic [7:0] bq_t [$];

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        req_valid;
    logic [7:0]  req_code;
    logic [31:0] req_args;
    logic        rsp_valid = 1'b0;
    logic [7:0]  h_status = 8'h00;
    logic [15:0] h_data = 16'h0000;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;

    int   checks = 0;
    int   fails = 0;
    bit   stall = 1'b0;
    int   rdy_cnt = 0;
    int   hdelay = 3;
    int   h_cnt = 0;
    bit   h_busy = 1'b0;
    int   req_cnt = 0;
    logic [7:0]  seen_code = '0;
    logic [31:0] seen_args = '0;
    bq_t  tx_log;
    bit   finished = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    cmd_frame_engine dut_i (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .req_valid  (req_valid),
        .req_code   (req_code),
        .req_args   (req_args),
        .rsp_valid  (rsp_valid),
        .rsp_status (h_status),
        .rsp_data   (h_data),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready)
    );

    // transmitter model: set ready, then log the byte the next edge takes
    always @(negedge clk) begin
        rdy_cnt++;
        tx_ready = stall ? (rdy_cnt % 3 == 0) : 1'b1;
        if (!rst && tx_valid && tx_ready) tx_log.push_back(tx_data);
    end

    // handler model
    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (rst) begin
            h_busy = 1'b0;
        end else if (req_valid && !h_busy) begin
            h_busy = 1'b1;
            h_cnt = hdelay;
            req_cnt++;
            seen_code = req_code;
            seen_args = req_args;
        end else if (h_busy) begin
            if (h_cnt <= 1) begin
                rsp_valid = 1'b1;
                h_busy = 1'b0;
            end else begin
                h_cnt--;
            end
        end
    end

    function automatic string q2s(bq_t q);
        string s = "";
        foreach (q[i]) s = {s, $sformatf("%02h ", q[i])};
        return s;
    endfunction

    task automatic chk_seq(string tag, bq_t exp);
        bit bad = (tx_log.size() != exp.size());
        checks++;
        if (!bad) foreach (exp[i]) if (tx_log[i] !== exp[i]) bad = 1'b1;
        if (bad) begin
            fails++;
            $display("FAIL %s: reply got [%s] expected [%s]", tag, q2s(tx_log), q2s(exp));
        end
    endtask

    task automatic chk_val(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic clear_obs();
        tx_log.delete();
        req_cnt = 0;
    endtask

    task automatic send(bq_t q);
        foreach (q[i]) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data = q[i];
            @(negedge clk);
            rx_valid = 1'b0;
        end
    endtask

    task automatic settle();
        repeat (120) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk_val("R1 tx_valid", 32'(tx_valid), 0);
        chk_val("R1 req_valid", 32'(req_valid), 0);
        clear_obs();
        repeat (10) @(negedge clk);
        chk_seq("R1 idle", '{});
    endtask

    task automatic t_enable_disable();
        clear_obs();
        h_status = 8'h00;
        send('{8'h01, 8'h44, 8'h01, 8'h44, 8'h04});
        settle();
        chk_val("R2 enable code", 32'(seen_code), 32'h01);
        chk_val("R2 enable args", seen_args, 32'h0);
        chk_seq("R2 enable reply", '{8'h06, 8'h44, 8'h00, 8'h44, 8'h04});
        clear_obs();
        h_status = 8'h02;
        send('{8'h01, 8'h44, 8'h00, 8'h44, 8'h04});
        settle();
        chk_val("R2 disable code", 32'(seen_code), 32'h00);
        chk_seq("R2 disable reply", '{8'h06, 8'h44, 8'h02, 8'h44, 8'h04});
    endtask

    task automatic t_read_analog();
        clear_obs();
        h_status = 8'h00;
        h_data = 16'hA55B;
        send('{8'h01, 8'h44, 8'h02, 8'h44, 8'h05, 8'h44, 8'h04});
        settle();
        chk_val("R3 args", seen_args, 32'h0000_0005);
        chk_seq("R3 reply", '{8'h06, 8'h44, 8'h00, 8'h44, 8'hA5, 8'h5B, 8'h44, 8'h04});
    endtask

    task automatic t_i2c_read();
        clear_obs();
        h_status = 8'h00;
        h_data = 16'h00C3;
        send('{8'h01, 8'h44, 8'h04, 8'h44, 8'h12, 8'h44, 8'h34, 8'h44, 8'h56, 8'h44, 8'h04});
        settle();
        chk_val("R4 args", seen_args, 32'h0056_3412);
        chk_seq("R4 reply", '{8'h06, 8'h44, 8'h00, 8'h44, 8'hC3, 8'h44, 8'h04});
    endtask

    task automatic t_i2c_write();
        clear_obs();
        h_status = 8'h00;
        send('{8'h01, 8'h44, 8'h05, 8'h44, 8'h12, 8'h44, 8'h34, 8'h44,
               8'h04, 8'h44, 8'h9E, 8'h44, 8'h04});
        settle();
        chk_val("R5 requests", 32'(req_cnt), 1);
        chk_val("R5 args", seen_args, 32'h9E04_3412);
        chk_seq("R5 reply", '{8'h06, 8'h44, 8'h00, 8'h44, 8'h04});
    endtask

    task automatic t_fail_status();
        clear_obs();
        h_status = 8'h08;
        h_data = 16'h1234;
        send('{8'h01, 8'h44, 8'h04, 8'h44, 8'h12, 8'h44, 8'h34, 8'h44, 8'h56, 8'h44, 8'h04});
        settle();
        chk_seq("R6 nack reply", '{8'h06, 8'h44, 8'h08, 8'h44, 8'h04});
        clear_obs();
        h_status = 8'h06;
        send('{8'h01, 8'h44, 8'h02, 8'h44, 8'h01, 8'h44, 8'h04});
        settle();
        chk_seq("R6 read fail reply", '{8'h06, 8'h44, 8'h06, 8'h44, 8'h04});
        h_status = 8'h00;
    endtask

    task automatic t_unknown();
        clear_obs();
        send('{8'h01, 8'h44, 8'h03, 8'h44, 8'h04});
        settle();
        chk_val("R7 code3 requests", 32'(req_cnt), 0);
        chk_seq("R7 code3 reply", '{8'h06, 8'h44, 8'h01, 8'h44, 8'h04});
        clear_obs();
        send('{8'h01, 8'h44, 8'h09, 8'h44, 8'h77, 8'h44, 8'h04});
        settle();
        chk_val("R7 code9 requests", 32'(req_cnt), 0);
        chk_seq("R7 code9 reply", '{8'h06, 8'h44, 8'h01, 8'h44, 8'h04});
    endtask

    task automatic t_bad_sep();
        clear_obs();
        send('{8'h01, 8'h44, 8'h01, 8'h22, 8'h04});
        settle();
        chk_val("R8 discard requests", 32'(req_cnt), 0);
        chk_seq("R8 discard reply", '{});
        send('{8'h01, 8'h44, 8'h00, 8'h44, 8'h04});
        settle();
        chk_val("R8 recovery code", 32'(seen_code), 32'h00);
        chk_seq("R8 recovery reply", '{8'h06, 8'h44, 8'h00, 8'h44, 8'h04});
    endtask

    task automatic t_noise();
        clear_obs();
        send('{8'h55, 8'h44, 8'h04, 8'h01, 8'h44, 8'h01, 8'h44, 8'h04});
        settle();
        chk_val("R9 requests", 32'(req_cnt), 1);
        chk_seq("R9 reply", '{8'h06, 8'h44, 8'h00, 8'h44, 8'h04});
    endtask

    task automatic t_overflow();
        clear_obs();
        send('{8'h01, 8'h44, 8'h07, 8'h44, 8'hAA, 8'h44, 8'hBB, 8'h44,
               8'hCC, 8'h44, 8'hDD, 8'h44, 8'hEE});
        settle();
        chk_val("R10 requests", 32'(req_cnt), 0);
        chk_seq("R10 reply", '{8'h06, 8'h44, 8'h09, 8'h44, 8'h04});
    endtask

    task automatic t_missing_end();
        clear_obs();
        send('{8'h01, 8'h44, 8'h00, 8'h44, 8'h55});
        settle();
        chk_val("R13 requests", 32'(req_cnt), 0);
        chk_seq("R13 reply", '{});
    endtask

    task automatic t_busy();
        clear_obs();
        hdelay = 40;
        send('{8'h01, 8'h44, 8'h01, 8'h44, 8'h04});
        send('{8'h01, 8'h44, 8'h00, 8'h44, 8'h04});
        settle();
        hdelay = 3;
        chk_val("R11 requests", 32'(req_cnt), 1);
        chk_val("R11 code", 32'(seen_code), 32'h01);
        chk_seq("R11 reply", '{8'h06, 8'h44, 8'h00, 8'h44, 8'h04});
    endtask

    task automatic t_stall();
        clear_obs();
        stall = 1'b1;
        h_data = 16'h3C81;
        send('{8'h01, 8'h44, 8'h02, 8'h44, 8'h09, 8'h44, 8'h04});
        settle();
        stall = 1'b0;
        chk_seq("R12 stalled reply", '{8'h06, 8'h44, 8'h00, 8'h44, 8'h3C, 8'h81, 8'h44, 8'h04});
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable_disable();
        t_read_analog();
        t_i2c_read();
        t_i2c_write();
        t_fail_status();
        t_unknown();
        t_bad_sep();
        t_noise();
        t_overflow();
        t_missing_end();
        t_busy();
        t_stall();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule